// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block produces an exact number of configuration clock pulses on request. The host writes a pulse count into a count register, and the block drives a clock output through that many pulses. Each pulse has a high phase and a low phase, and each phase lasts a parameterised number of system clocks. When the last pulse has finished, the block raises a sticky done flag in a status register. The host clears that flag by writing a one to it. The usual routine is to clear the flag, write the count, poll until the flag is set, and then clear it again.

The register port is a plain single-cycle write strobe with an address and write data. Reads are combinational from the address. While a burst is running, the count register reads back the number of pulses that are still to be produced.

Top module: `clkburst_gen`

## Requirements
- R1: After reset the clock output is low, the done flag (status register at address 0x0C, bit 0) reads 0, and the count register at address 0x08 reads 0.
- R2: A write of a nonzero value N to address 0x08 while idle starts a burst of exactly N pulses, for any N up to 2^32-1, including 256 and 2047. The clock output is high in the cycle after the write edge.
- R3: Each pulse is high for PHASE_LEN system clocks and then low for PHASE_LEN system clocks. The clock output is low whenever no burst is running.
- R4: The done flag is set on the edge that ends the low phase of the final pulse, so it reads 1 exactly 2*PHASE_LEN*N cycles after the starting write edge. It stays set until it is cleared.
- R5: A write to address 0x0C with bit 0 of the data at 1 clears the done flag. A write there with bit 0 at 0 leaves the flag unchanged.
- R6: A write to address 0x08 during a burst is ignored. The running burst keeps its pulse count and its timing, and the read-back count is not replaced by the written value.
- R7: A write of 0 to address 0x08 while idle sets the done flag on the write edge and produces no pulse.
- R8: Reading address 0x08 returns the number of pulses still owed. The value drops by one at the end of each pulse's low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dclk | output | 1 | Configuration clock output, low when idle |

## Verification
The bench builds the block with PHASE_LEN set to 3. With that value the phase timer must wrap at a length that is not a power of two, and each pulse takes six system clocks. This makes the full 2047-pulse burst and the 256-pulse burst fit easily within the run, so the exact cycle count from the start write to the done flag can be compared for both sizes. The register width is left at 32 bits, so the count values used are the ones a host would really write.

// File: rtl/clkburst_pkg.sv
package clkburst_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h0C;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             start;
        logic [REG_W-1:0] len;
        logic             clr_done;
    } burst_cmd_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] ofs);
        return a == ofs;
    endfunction

endpackage

// File: rtl/clkburst_regif.sv
module clkburst_regif
    import clkburst_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    input  logic [REG_W-1:0]  remaining,
    input  logic              done,
    output burst_cmd_t        cmd,
    output logic [REG_W-1:0]  reg_rdata
);

    always_comb begin
        cmd.start    = reg_wr && addr_hit(reg_addr, ADDR_COUNT) && !busy;
        cmd.len      = reg_wdata;
        cmd.clr_done = reg_wr && addr_hit(reg_addr, ADDR_STATUS) && reg_wdata[0];
    end

    always_comb begin
        if (addr_hit(reg_addr, ADDR_COUNT))
            reg_rdata = remaining;
        else if (addr_hit(reg_addr, ADDR_STATUS))
            reg_rdata = {{(REG_W-1){1'b0}}, done};
        else
            reg_rdata = '0;
    end

endmodule

// File: rtl/clkburst_phase_timer.sv
module clkburst_phase_timer #(
    parameter int PHASE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);

    localparam int TMR_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PHASE_LEN - 1);

    logic [TMR_W-1:0] tmr_q;

    assign phase_end = run && (tmr_q == TMR_LAST);

    always_ff @(posedge clk) begin
        if (rst || phase_end || !run)
            tmr_q <= '0;
        else
            tmr_q <= tmr_q + 1'b1;
    end

endmodule

// File: rtl/clkburst_seq.sv
module clkburst_seq
    import clkburst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  burst_cmd_t       cmd,
    input  logic             phase_end,
    output logic             busy,
    output logic             dclk,
    output logic             done,
    output logic [REG_W-1:0] remaining
);

    phase_e           state_q;
    logic [REG_W-1:0] rem_q;
    logic             dclk_q;
    logic             done_q;
    logic             set_done;
    logic             last_pulse;

    assign last_pulse = (rem_q == REG_W'(1));

    always_comb begin
        set_done = 1'b0;
        if (state_q == PH_IDLE && cmd.start && cmd.len == '0)
            set_done = 1'b1;
        else if (state_q == PH_LOW && phase_end && last_pulse)
            set_done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            rem_q   <= '0;
            dclk_q  <= 1'b0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (cmd.start && cmd.len != '0) begin
                        state_q <= PH_HIGH;
                        rem_q   <= cmd.len;
                        dclk_q  <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (phase_end) begin
                        state_q <= PH_LOW;
                        dclk_q  <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (phase_end) begin
                        rem_q <= rem_q - 1'b1;
                        if (last_pulse) begin
                            state_q <= PH_IDLE;
                        end else begin
                            state_q <= PH_HIGH;
                            dclk_q  <= 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= PH_IDLE;
                    dclk_q  <= 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (set_done)
            done_q <= 1'b1;
        else if (cmd.clr_done)
            done_q <= 1'b0;
    end

    assign busy      = (state_q != PH_IDLE);
    assign dclk      = dclk_q;
    assign done      = done_q;
    assign remaining = rem_q;

endmodule

// File: rtl/clkburst_gen.sv
module clkburst_gen
    import clkburst_pkg::*;
#(
    parameter int PHASE_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dclk
);

    burst_cmd_t       cmd;
    logic             busy;
    logic             done;
    logic             phase_end;
    logic [REG_W-1:0] remaining;

    clkburst_regif u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .remaining (remaining),
        .done      (done),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    clkburst_phase_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .phase_end (phase_end)
    );

    clkburst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .phase_end (phase_end),
        .busy      (busy),
        .dclk      (dclk),
        .done      (done),
        .remaining (remaining)
    );

endmodule

// File: rtl/clkburst_gen_chk.sv
module clkburst_gen_chk
    import clkburst_pkg::*;
#(
    parameter int PHASE_LEN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              dclk,
    input logic              busy,
    input logic              done,
    input logic [REG_W-1:0]  remaining
);

    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 0;
        else if (dclk)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dclk);

    assert_high_width_R3: assert property (@(posedge clk) disable iff (rst)
        (!dclk && hi_run != 0) |-> hi_run == PHASE_LEN);

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_addr == ADDR_COUNT && reg_wdata != '0)
        |=> (dclk && busy && remaining == $past(reg_wdata)));

    assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_addr == ADDR_COUNT && reg_wdata == '0)
        |=> (done && !dclk && !busy));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_addr == ADDR_STATUS && reg_wdata[0]) |=> !done);

    assert_w0_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (done && reg_wr && reg_addr == ADDR_STATUS && !reg_wdata[0]) |=> done);

    assert_busy_write_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == ADDR_COUNT)
        |=> (remaining == $past(remaining) || remaining == $past(remaining) - 1));

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && remaining == REG_W'(1) && !dclk && hi_run == 0 && $fell(busy) == 1'b0)
        |-> !done || $past(done));

endmodule

bind clkburst_gen clkburst_gen_chk #(.PHASE_LEN(PHASE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dclk      (dclk),
    .busy      (busy),
    .done      (done),
    .remaining (remaining)
);

// File: tb/clkburst_gen_bench.sv
module clkburst_gen_bench;

    localparam int PH = 3;
    localparam logic [7:0] A_CNT  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;

    typedef struct packed {
        int unsigned len;
        int unsigned pulses;
        int unsigned cycles;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd1,    32'd1,    32'(2*PH*1)},
        '{32'd2,    32'd2,    32'(2*PH*2)},
        '{32'd3,    32'd3,    32'(2*PH*3)},
        '{32'd7,    32'd7,    32'(2*PH*7)},
        '{32'd256,  32'd256,  32'(2*PH*256)},
        '{32'd2047, 32'd2047, 32'(2*PH*2047)}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dclk;

    int nchecks = 0;
    int nerrors = 0;
    int unsigned rise_total = 0;
    int unsigned hi_len = 0;
    logic prev_dclk = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    clkburst_gen #(.PHASE_LEN(PH)) u_clkburst_gen (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dclk      (dclk)
    );

    task automatic check(input string req, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nerrors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pulse count and high width (R2, R3)
    always @(negedge clk) begin
        if (!rst) begin
            if (dclk && !prev_dclk) rise_total++;
            if (!dclk && prev_dclk) check("R3 high width", hi_len, PH);
            hi_len = dclk ? hi_len + 1 : 0;
        end
        prev_dclk = dclk;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(output int unsigned n);
        logic [31:0] s;
        n = 0;
        rd(A_STAT, s);
        while (!s[0] && n < 20000) begin
            @(negedge clk);
            n++;
            rd(A_STAT, s);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerrors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        int unsigned n, r0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 dclk", dclk, 0);
        rd(A_STAT, v); check("R1 done", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);

        // Table walk: R2, R4
        for (int i = 0; i < NV; i++) begin
            wr(A_STAT, 32'h1);
            r0 = rise_total;
            wr(A_CNT, VECS[i].len);
            check("R2 dclk high after start", dclk, 1);
            wait_done(n);
            check("R4 cycles to done", n, VECS[i].cycles);
            @(negedge clk);
            check("R2 pulse count", rise_total - r0, VECS[i].pulses);
            check("R3 idle low", dclk, 0);
            rd(A_STAT, v); check("R4 done sticky", v[0], 1);
        end

        // R5 write zero keeps, write one clears
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); check("R5 write0 keeps", v[0], 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); check("R5 write1 clears", v[0], 0);

        // R7 zero count
        r0 = rise_total;
        wr(A_CNT, 32'd0);
        rd(A_STAT, v); check("R7 done next cycle", v[0], 1);
        repeat (2*PH) @(negedge clk);
        check("R7 no pulses", rise_total - r0, 0);
        wr(A_STAT, 32'h1);

        // R8 remaining readback
        wr(A_CNT, 32'd5);
        rd(A_CNT, v); check("R8 count loaded", v, 5);
        repeat (2*PH) @(negedge clk);
        rd(A_CNT, v); check("R8 after one pulse", v, 4);
        wait_done(n);
        rd(A_CNT, v); check("R8 zero at end", v, 0);
        wr(A_STAT, 32'h1);

        // R6 write during burst ignored
        r0 = rise_total;
        wr(A_CNT, 32'd10);
        repeat (4) @(negedge clk);
        wr(A_CNT, 32'd3);
        rd(A_CNT, v); check("R6 count not replaced", v, 9);
        wait_done(n);
        check("R6 cycles unchanged", n + 6, 2*PH*10);
        @(negedge clk);
        check("R6 pulse count", rise_total - r0, 10);
        rd(A_STAT, v); check("R6 done", v[0], 1);

        summary();
    end

endmodule